// File: doc/BRIEF.md
# Register-Fed Tile ALU

This block is one arithmetic unit of a coarse-grained reconfigurable processing tile. It has four 16-bit operand lanes. Each lane reads only from a private four-entry register file. An interconnect fills each file by index. No path carries a value from the interconnect straight into the arithmetic, so every operand has spent at least one clock in a register.

The function logic holds no state and has no pipeline stage. One configured instruction drives two identical function units, one fed by lanes A and B and one fed by lanes C and D. A second-level adder can join the two unit results. Two 16-bit outputs each pick one of four sources. The west output is meant for the east input of the neighbouring ALU on the left, and this ALU's own `eastIn` can be routed to either output.

There is no fixed instruction set. An eight-entry instruction store is written through a configuration port. An external sequencer chooses the live entry with `instrSel`, and that choice takes effect combinationally.

Top module: `regfed_alu`

## Requirements
- R1: An active-low asynchronous reset clears every register-file entry and every instruction entry. With the cleared entry 0 selected, both outputs read 0.
- R2: Operands come only from the register files. A register-file or instruction write at clock edge N first shows on the outputs after that edge. In the cycle the write is presented, the outputs still reflect the old contents.
- R3: Each lane has its own write enable, 2-bit index and 16-bit data. All four lanes may write in the same cycle, independently. Lane L uses `rfWrIdx[2L+1:2L]` and `rfWrData[16L+15:16L]`.
- R4: The instruction store holds 8 entries of 17 bits, written at `cfgWrAddr` when `cfgWrEn` is high. The field layout is: bits [1:0] lane A index, [3:2] lane B index, [5:4] lane C index, [7:6] lane D index, [11:8] op code, [12] saturate enable, [14:13] main source, [16:15] west source. `instrSel` picks the active entry.
- R5: Op 0 adds and op 1 subtracts (first minus second) as 16-bit two's complement. With saturate clear, the result wraps modulo 2^16.
- R6: Op 2 is AND, op 3 is OR, op 4 is XOR, and op 5 is the bitwise NOT of the first operand.
- R7: The shift amount is the low 4 bits of the second operand. Op 6 shifts left, op 7 shifts right logically, and op 8 shifts right arithmetically.
- R8: Op 9 gives 1 when the first operand is less than the second as signed values, else 0. Op 10 gives 1 on equality, else 0.
- R9: Op 11 passes the first operand through unchanged. Op codes 12 to 15 produce 0.
- R10: With saturate set, add, subtract and the second-level adder clamp signed overflow to 0x7FFF or 0x8000.
- R11: Each output source code selects as follows: 0 gives unit 1 (A op B), 1 gives unit 2 (C op D), 2 gives `eastIn`, and 3 gives the sum of the two unit results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rfWrEn | input | 4 | Per-lane register-file write enable |
| rfWrIdx | input | 8 | Per-lane write index, 2 bits per lane |
| rfWrData | input | 64 | Per-lane write data, 16 bits per lane |
| cfgWrEn | input | 1 | Instruction store write enable |
| cfgWrAddr | input | 3 | Instruction entry being written |
| cfgWrData | input | 17 | Instruction word |
| instrSel | input | 3 | Active instruction entry from the sequencer |
| eastIn | input | 16 | Result from the right-hand neighbour |
| outMain | output | 16 | Main result |
| outWest | output | 16 | Result toward the left-hand neighbour |

## Verification
The bench builds the block with its default 16-bit datapath and eight instruction entries. At that width the saturation limits 0x7FFF and 0x8000 can be driven directly as directed corner cases, and shifts by 15 can be aimed at the sign bit. With eight entries, random rewriting reaches every entry, every source-select code and all sixteen op codes, including the four unused ones. Random register and instruction writes land in the same cycles as selector changes, which tests the one-cycle write-to-output rule against a bench model of both stores.

// File: rtl/regfed_alu_pkg.sv
package regfed_alu_pkg;
  localparam int NUM_IN   = 4;
  localparam int RF_DEPTH = 4;
  localparam int IDX_W    = $clog2(RF_DEPTH);
  localparam int OP_W     = 4;
  localparam int SEL_W    = 2;
  localparam int NUM_FN   = 12;

  // op codes; codes from NUM_FN upward produce zero
  localparam int FN_ADD  = 0;
  localparam int FN_SUB  = 1;
  localparam int FN_AND  = 2;
  localparam int FN_OR   = 3;
  localparam int FN_XOR  = 4;
  localparam int FN_NOT  = 5;
  localparam int FN_SHL  = 6;
  localparam int FN_SHR  = 7;
  localparam int FN_SAR  = 8;
  localparam int FN_LT   = 9;
  localparam int FN_EQ   = 10;
  localparam int FN_PASS = 11;

  typedef enum logic [SEL_W-1:0] {
    SRC_UNIT1 = 2'd0,
    SRC_UNIT2 = 2'd1,
    SRC_EAST  = 2'd2,
    SRC_SUM   = 2'd3
  } src_e;

  // stored instruction word, MSB first
  typedef struct packed {
    src_e                        selWest;
    src_e                        selMain;
    logic                        satEn;
    logic [OP_W-1:0]             op;
    logic [NUM_IN-1:0][IDX_W-1:0] rdIdx;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_IN-1:0][IDX_W-1:0] rdIdx;
    logic [NUM_FN-1:0]           fnHot;
    logic                        satEn;
    src_e                        selMain;
    src_e                        selWest;
  } ctrl_t;
endpackage

// File: rtl/regfed_alu_ctrl.sv
module regfed_alu_ctrl
  import regfed_alu_pkg::*;
#(
  parameter int INSTR_DEPTH = 8,
  localparam int CFG_AW = $clog2(INSTR_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CFG_AW-1:0]  cfgWrAddr,
  input  logic [INSTR_W-1:0] cfgWrData,
  input  logic [CFG_AW-1:0]  instrSel,
  output ctrl_t              ctrl
);
  instr_t store [INSTR_DEPTH];
  instr_t cur;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < INSTR_DEPTH; e++) store[e] <= '0;
    end else if (cfgWrEn) begin
      store[cfgWrAddr] <= instr_t'(cfgWrData);
    end
  end

  assign cur = store[instrSel];

  always_comb begin
    ctrl.rdIdx   = cur.rdIdx;
    ctrl.satEn   = cur.satEn;
    ctrl.selMain = cur.selMain;
    ctrl.selWest = cur.selWest;
    for (int k = 0; k < NUM_FN; k++) begin
      ctrl.fnHot[k] = (cur.op == OP_W'(k));
    end
  end
endmodule

// File: rtl/regfed_alu_dp.sv
module regfed_alu_dp
  import regfed_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        rfWrEn,
  input  logic [NUM_IN*IDX_W-1:0]  rfWrIdx,
  input  logic [NUM_IN*DATA_W-1:0] rfWrData,
  input  ctrl_t                    ctrl,
  input  logic [DATA_W-1:0]        eastIn,
  output logic [DATA_W-1:0]        outMain,
  output logic [DATA_W-1:0]        outWest
);
  logic [DATA_W-1:0] opnd [NUM_IN];
  logic [DATA_W-1:0] unit1, unit2, sum2;

  // private register file per lane; the only operand source
  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    logic [DATA_W-1:0] rf [RF_DEPTH];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int e = 0; e < RF_DEPTH; e++) rf[e] <= '0;
      end else if (rfWrEn[g]) begin
        rf[rfWrIdx[g*IDX_W +: IDX_W]] <= rfWrData[g*DATA_W +: DATA_W];
      end
    end
    assign opnd[g] = rf[ctrl.rdIdx[g]];
  end

  function automatic logic [DATA_W-1:0] addSat(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y,
                                               input logic doSub,
                                               input logic doSat);
    logic [DATA_W:0] wide;
    wide = doSub ? ({x[DATA_W-1], x} - {y[DATA_W-1], y})
                 : ({x[DATA_W-1], x} + {y[DATA_W-1], y});
    if (doSat && (wide[DATA_W] != wide[DATA_W-1])) begin
      return wide[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    end
    return wide[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] evalUnit(input logic [NUM_FN-1:0] hot,
                                                 input logic sat,
                                                 input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    logic [DATA_W-1:0] r;
    logic [SH_W-1:0]   amt;
    amt = y[SH_W-1:0];
    r   = '0;
    if (hot[FN_ADD])  r |= addSat(x, y, 1'b0, sat);
    if (hot[FN_SUB])  r |= addSat(x, y, 1'b1, sat);
    if (hot[FN_AND])  r |= x & y;
    if (hot[FN_OR])   r |= x | y;
    if (hot[FN_XOR])  r |= x ^ y;
    if (hot[FN_NOT])  r |= ~x;
    if (hot[FN_SHL])  r |= x << amt;
    if (hot[FN_SHR])  r |= x >> amt;
    if (hot[FN_SAR])  r |= DATA_W'($signed(x) >>> amt);
    if (hot[FN_LT])   r |= {{(DATA_W-1){1'b0}}, ($signed(x) < $signed(y))};
    if (hot[FN_EQ])   r |= {{(DATA_W-1){1'b0}}, (x == y)};
    if (hot[FN_PASS]) r |= x;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pick(input src_e s);
    case (s)
      SRC_UNIT1: return unit1;
      SRC_UNIT2: return unit2;
      SRC_EAST:  return eastIn;
      default:   return sum2;
    endcase
  endfunction

  always_comb begin
    unit1   = evalUnit(ctrl.fnHot, ctrl.satEn, opnd[0], opnd[1]);
    unit2   = evalUnit(ctrl.fnHot, ctrl.satEn, opnd[2], opnd[3]);
    sum2    = addSat(unit1, unit2, 1'b0, ctrl.satEn);
    outMain = pick(ctrl.selMain);
    outWest = pick(ctrl.selWest);
  end
endmodule

// File: rtl/regfed_alu.sv
module regfed_alu
  import regfed_alu_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int INSTR_DEPTH = 8,
  localparam int CFG_AW = $clog2(INSTR_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        rfWrEn,
  input  logic [NUM_IN*IDX_W-1:0]  rfWrIdx,
  input  logic [NUM_IN*DATA_W-1:0] rfWrData,
  input  logic                     cfgWrEn,
  input  logic [CFG_AW-1:0]        cfgWrAddr,
  input  logic [INSTR_W-1:0]       cfgWrData,
  input  logic [CFG_AW-1:0]        instrSel,
  input  logic [DATA_W-1:0]        eastIn,
  output logic [DATA_W-1:0]        outMain,
  output logic [DATA_W-1:0]        outWest
);
  ctrl_t ctrl;

  regfed_alu_ctrl #(.INSTR_DEPTH(INSTR_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .instrSel(instrSel), .ctrl(ctrl)
  );

  regfed_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .ctrl(ctrl), .eastIn(eastIn),
    .outMain(outMain), .outWest(outWest)
  );
endmodule

// File: rtl/regfed_alu_chk.sv
module regfed_alu_chk
  import regfed_alu_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int INSTR_DEPTH = 8,
  localparam int CFG_AW = $clog2(INSTR_DEPTH)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_IN-1:0]        rfWrEn,
  input logic                     cfgWrEn,
  input logic [CFG_AW-1:0]        cfgWrAddr,
  input logic [INSTR_W-1:0]       cfgWrData,
  input logic [CFG_AW-1:0]        instrSel,
  input logic [DATA_W-1:0]        eastIn,
  input logic [DATA_W-1:0]        outMain,
  input logic [DATA_W-1:0]        outWest
);
  // shadow of the instruction store, filled from the configuration port
  logic [INSTR_W-1:0] shadow [INSTR_DEPTH];
  instr_t cur;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < INSTR_DEPTH; e++) shadow[e] <= '0;
    end else if (cfgWrEn) begin
      shadow[cfgWrAddr] <= cfgWrData;
    end
  end

  assign cur = instr_t'(shadow[instrSel]);

  p_reset_zero_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (outMain == '0 && outWest == '0));

  p_no_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rfWrEn) == '0 && !$past(cfgWrEn) && $stable(instrSel) && $stable(eastIn))
      |-> ($stable(outMain) && $stable(outWest)));

  p_east_main_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cur.selMain == SRC_EAST) |-> (outMain == eastIn));

  p_east_west_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cur.selWest == SRC_EAST) |-> (outWest == eastIn));

  p_cmp_bool_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((cur.op == OP_W'(FN_LT) || cur.op == OP_W'(FN_EQ)) && cur.selMain == SRC_UNIT1)
      |-> (outMain[DATA_W-1:1] == '0));
endmodule

bind regfed_alu regfed_alu_chk #(.DATA_W(DATA_W), .INSTR_DEPTH(INSTR_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .rfWrEn(rfWrEn), .cfgWrEn(cfgWrEn),
  .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData), .instrSel(instrSel),
  .eastIn(eastIn), .outMain(outMain), .outWest(outWest)
);

// File: tb/regfed_alu_test.sv
module regfed_alu_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rfWrEn = '0;
  logic [7:0]  rfWrIdx = '0;
  logic [63:0] rfWrData = '0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgWrAddr = '0;
  logic [16:0] cfgWrData = '0;
  logic [2:0]  instrSel = '0;
  logic [15:0] eastIn = '0;
  logic [15:0] outMain, outWest;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] mRf [4][4];
  logic [16:0] mIns [8];

  always #5 clk = ~clk;

  regfed_alu uut (
    .clk(clk), .rstN(rstN), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .instrSel(instrSel), .eastIn(eastIn),
    .outMain(outMain), .outWest(outWest)
  );

  function automatic logic [15:0] expFn(input int op, input bit sat,
                                        input logic [15:0] x, input logic [15:0] y);
    int sx, sy, r;
    sx = int'($signed(x));
    sy = int'($signed(y));
    case (op)
      0, 1: begin
        r = (op == 0) ? sx + sy : sx - sy;
        if (sat && r > 32767) r = 32767;
        if (sat && r < -32768) r = -32768;
        return r[15:0];
      end
      2: return x & y;
      3: return x | y;
      4: return x ^ y;
      5: return ~x;
      6: return x << y[3:0];
      7: return x >> y[3:0];
      8: return 16'($signed(x) >>> y[3:0]);
      9: return (sx < sy) ? 16'd1 : 16'd0;
      10: return (x == y) ? 16'd1 : 16'd0;
      11: return x;
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tagFor(input int op, input bit sat, input int sel);
    if (sel == 2) return "R11";
    if (sel == 3) return sat ? "R10" : "R11";
    if (op <= 1) return sat ? "R10" : "R5";
    if (op <= 5) return "R6";
    if (op <= 8) return "R7";
    if (op <= 10) return "R8";
    return "R9";
  endfunction

  function automatic logic [16:0] mkIns(input int a, input int b, input int c, input int d,
                                        input int op, input int sat, input int sm, input int sw);
    return {2'(sw), 2'(sm), 1'(sat), 4'(op), 2'(d), 2'(c), 2'(b), 2'(a)};
  endfunction

  task automatic chk(input string tag);
    logic [16:0] w;
    logic [15:0] u1, u2, sm, eM, eW;
    int op, selM, selW;
    bit sat;
    string tM, tW;
    w = mIns[instrSel];
    op = int'(w[11:8]);
    sat = w[12];
    selM = int'(w[14:13]);
    selW = int'(w[16:15]);
    u1 = expFn(op, sat, mRf[0][w[1:0]], mRf[1][w[3:2]]);
    u2 = expFn(op, sat, mRf[2][w[5:4]], mRf[3][w[7:6]]);
    sm = expFn(0, sat, u1, u2);
    eM = (selM == 0) ? u1 : (selM == 1) ? u2 : (selM == 2) ? eastIn : sm;
    eW = (selW == 0) ? u1 : (selW == 1) ? u2 : (selW == 2) ? eastIn : sm;
    tM = (tag == "") ? tagFor(op, sat, selM) : tag;
    tW = (tag == "") ? tagFor(op, sat, selW) : tag;
    checks += 2;
    if (outMain !== eM) begin
      errors++;
      $display("FAIL %s outMain actual %h expected %h (op %0d sel %0d)", tM, outMain, eM, op, selM);
    end
    if (outWest !== eW) begin
      errors++;
      $display("FAIL %s outWest actual %h expected %h (op %0d sel %0d)", tW, outWest, eW, op, selW);
    end
  endtask

  // waits for the edge that takes the driven writes, mirrors them, then drops enables
  task automatic commit();
    @(posedge clk);
    for (int l = 0; l < 4; l++)
      if (rfWrEn[l]) mRf[l][rfWrIdx[l*2 +: 2]] = rfWrData[l*16 +: 16];
    if (cfgWrEn) mIns[cfgWrAddr] = cfgWrData;
    #1;
    rfWrEn = '0;
    cfgWrEn = 1'b0;
  endtask

  task automatic putRf(input int l, input int idx, input logic [15:0] d);
    @(negedge clk);
    rfWrEn[l] = 1'b1;
    rfWrIdx[l*2 +: 2] = 2'(idx);
    rfWrData[l*16 +: 16] = d;
    commit();
  endtask

  task automatic putIns(input int a, input logic [16:0] w);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrAddr = 3'(a);
    cfgWrData = w;
    commit();
  endtask

  task automatic selAndChk(input int s, input logic [15:0] e, input string tag);
    @(negedge clk);
    instrSel = 3'(s);
    eastIn = e;
    #1;
    chk(tag);
  endtask

  function automatic logic [15:0] pickVal();
    case ($urandom_range(0, 5))
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'hFFFF;
      3: return 16'h0000;
      4: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int l = 0; l < 4; l++) for (int e = 0; e < 4; e++) mRf[l][e] = '0;
    for (int e = 0; e < 8; e++) mIns[e] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1");  // R1: cleared entry 0 is ADD of zero operands

    // R3: all four lanes written in one cycle, different indices
    @(negedge clk);
    rfWrEn = 4'hF;
    rfWrIdx = {2'd0, 2'd3, 2'd2, 2'd1};
    rfWrData = {16'h0001, 16'h8000, 16'h0001, 16'h7FFF};
    commit();
    putRf(3, 1, 16'h000F);

    // R4 + R5: wrapped add at entry 5, main from unit 1, west from unit 2
    putIns(5, mkIns(1, 2, 3, 0, 0, 0, 0, 1));
    selAndChk(5, 16'h1234, "R5");
    // R10: saturated subtract, unit 2 clamps at 0x8000, west takes the level-2 sum
    putIns(6, mkIns(1, 2, 3, 0, 1, 1, 1, 3));
    selAndChk(6, 16'h0, "R10");
    // R10: saturated add of 0x7FFF and 1
    putIns(4, mkIns(1, 2, 3, 0, 0, 1, 0, 3));
    selAndChk(4, 16'h0, "R10");
    // R7: arithmetic shift of 0x8000 by 15 on unit 2; west passes east
    putIns(7, mkIns(1, 2, 3, 1, 8, 0, 1, 2));
    selAndChk(7, 16'hBEEF, "R7");
    // R8: signed less-than and equality
    putIns(3, mkIns(2, 1, 3, 0, 9, 0, 0, 1));
    selAndChk(3, 16'h0, "R8");
    putIns(2, mkIns(1, 1, 0, 0, 10, 0, 0, 1));
    selAndChk(2, 16'h0, "R8");
    // R9: unused op code gives zero
    putIns(1, mkIns(1, 2, 3, 0, 13, 0, 0, 1));
    selAndChk(1, 16'h0, "R9");

    // R2: a write presented this cycle is not yet visible
    selAndChk(5, 16'h0, "R2");
    @(negedge clk);
    rfWrEn[0] = 1'b1;
    rfWrIdx[1:0] = 2'd1;
    rfWrData[15:0] = 16'h0100;
    #1;
    chk("R2");
    commit();
    @(negedge clk);
    #1;
    chk("R2");
    // R4: rewriting an entry while it is selected takes effect after the edge
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrAddr = 3'd5;
    cfgWrData = mkIns(1, 2, 3, 0, 4, 0, 2, 0);
    #1;
    chk("R4");
    commit();
    @(negedge clk);
    #1;
    chk("R4");

    // constrained random traffic
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      #1;
      chk("");
      for (int l = 0; l < 4; l++) begin
        rfWrEn[l] = ($urandom_range(0, 2) == 0);
        rfWrIdx[l*2 +: 2] = 2'($urandom);
        rfWrData[l*16 +: 16] = pickVal();
      end
      cfgWrEn = ($urandom_range(0, 3) == 0);
      cfgWrAddr = 3'($urandom);
      cfgWrData = 17'($urandom);
      instrSel = 3'($urandom);
      eastIn = pickVal();
      commit();
    end
    @(negedge clk);
    #1;
    chk("");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule